// File: doc/BRIEF.md
# DAC Sample-and-Hold Phase Sequencer

This block times one DAC output channel that runs in sample-and-hold mode to save power. In a slow low-speed clock domain it steps through a charge phase (sample), a gated phase (hold) and a top-up phase (refresh). During hold the DAC core and its output buffer are powered down, the output pin is tri-stated and the hold capacitor is left floating. During sample and refresh the core and buffer drive the capacitor. After start-up the channel loops between hold and refresh. A full sample phase runs only when the channel is enabled or when a new conversion is requested.

Software sets the three phase lengths through a small write port on the fast bus clock. The hold and refresh lengths are static settings. They are changed only while the channel is disabled, and the slow domain reads them directly. The sample length can be changed while the channel runs. Each write starts a toggle handshake into the slow domain. A busy flag is high until the slow domain has acknowledged the write. Writes that arrive during that time are dropped. A new sample length is used from the start of the next sample phase.

The analog parts are outside this block: the converter, the buffer and the capacitor. The block has no data path, trigger or DMA handling.

Top module: `sh_dac_seq`

## Requirements
- R1: With the channel idle, raising `en` starts a sample phase (phase code 1) on the next low-speed edge. A sample phase lasts N+1 low-speed cycles, where N is the sample register (write select 0).
- R2: When a sample phase ends, the channel enters hold (phase code 2). Hold lasts H low-speed cycles, where H is the hold register (write select 1).
- R3: When a hold phase ends, the channel enters refresh (phase code 3) for R low-speed cycles, where R is the refresh register (write select 2). When refresh ends, the channel returns to hold, so the loop is hold, refresh, hold, and so on.
- R4: The control outputs follow the phase:
  - In idle (phase code 0) and in hold, `core_on`=0, `buf_on`=0, `out_hiz`=1 and `cap_conn`=0.
  - In sample and in refresh, `core_on`=1, `buf_on`=1, `out_hiz`=0 and `cap_conn`=1.
- R5: A write to select 0 while `busy` is low stores the value. `busy` is high one bus cycle later, and it falls again once the value has reached the low-speed domain.
- R6: A write to select 0 while `busy` is high is ignored. The value sent to the low-speed domain is the one already in flight.
- R7: A sample value that arrives in the low-speed domain during a sample phase does not change the length of that phase. It first applies to the next sample phase.
- R8: While enabled in hold or refresh, a one-cycle `conv_req` starts a sample phase on the next low-speed edge. In sample or idle, `conv_req` is ignored.
- R9: With `en` low, the channel is idle from the next low-speed edge, with the idle outputs of R4.
- R10: A hold or refresh register value of 0 gives a phase of exactly one low-speed cycle.
- R11: After reset the phase is idle (code 0), `busy` is 0 and all three registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Fast bus clock for the register write port |
| clk_ls | input | 1 | Low-speed clock that times the phases |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe (bus clock) |
| wr_sel | input | 2 | Register select: 0 sample, 1 hold, 2 refresh |
| wr_data | input | 10 | Write data; refresh uses the low 8 bits |
| busy | output | 1 | Sample value crossing into the low-speed domain |
| en | input | 1 | Channel enable (low-speed clock) |
| conv_req | input | 1 | New conversion request, one low-speed cycle |
| phase | output | 2 | Current phase: 0 idle, 1 sample, 2 hold, 3 refresh |
| core_on | output | 1 | DAC core power enable |
| buf_on | output | 1 | Output buffer power enable |
| out_hiz | output | 1 | Tri-state the output pin |
| cap_conn | output | 1 | Connect the hold capacitor to the buffer |

## Verification
All phase outputs come straight from registers clocked by `clk_ls`. An `en` or `conv_req` change driven at a falling low-speed edge therefore shows up at the next falling edge, and the bench checks one low-speed cycle later. Phase lengths are measured by counting falling low-speed edges with an unchanged phase code. `busy` is checked at the bus falling edge right after the write edge. Its release is due within three low-speed and three bus cycles, and the bench polls for it with a bound of 60 bus cycles. The effect of a sample write is judged by the length of a later sample phase, which follows from R1 and R7.

// File: rtl/shseq_pkg.sv
package shseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_HOLD    = 2'd2,
    PH_REFRESH = 2'd3
  } phase_e;

  localparam logic [1:0] SEL_SAMPLE  = 2'd0;
  localparam logic [1:0] SEL_HOLD    = 2'd1;
  localparam logic [1:0] SEL_REFRESH = 2'd2;

  // Counter preload for a phase of v cycles, where 0 counts as one cycle.
  function automatic logic [15:0] min1_preload(input logic [15:0] v);
    return (v == 16'd0) ? 16'd0 : v - 16'd1;
  endfunction

  // Active outputs {core, buf, hiz, cap} for a phase.
  function automatic logic [3:0] phase_ctrl(input phase_e p);
    return (p == PH_SAMPLE || p == PH_REFRESH) ? 4'b1101 : 4'b0010;
  endfunction
endpackage

// File: rtl/sh_sync.sv
module sh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sh_busregs.sv
module sh_busregs
  import shseq_pkg::*;
#(
  parameter int SW = 10,
  parameter int HW = 10,
  parameter int RW = 8,
  parameter int DW = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_bus,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          ack_tgl,
  output logic [SW-1:0] samp_q,
  output logic [HW-1:0] hold_q,
  output logic [RW-1:0] ref_q,
  output logic          req_tgl,
  output logic          busy,
  output logic          samp_take,
  output logic          samp_drop
);
  logic ack_s;

  sh_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_bus), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  assign busy      = req_tgl ^ ack_s;
  assign samp_take = wr_en && (wr_sel == SEL_SAMPLE) && !busy;
  assign samp_drop = wr_en && (wr_sel == SEL_SAMPLE) && busy;

  always_ff @(posedge clk_bus or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      hold_q  <= '0;
      ref_q   <= '0;
      req_tgl <= 1'b0;
    end else begin
      if (samp_take) begin
        samp_q  <= wr_data[SW-1:0];
        req_tgl <= ~req_tgl;
      end
      if (wr_en && wr_sel == SEL_HOLD)    hold_q <= wr_data[HW-1:0];
      if (wr_en && wr_sel == SEL_REFRESH) ref_q  <= wr_data[RW-1:0];
    end
  end
endmodule

// File: rtl/sh_ls_rx.sv
module sh_ls_rx #(
  parameter int SW = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_ls,
  input  logic          rst_n,
  input  logic          req_tgl,
  input  logic [SW-1:0] samp_bus,
  output logic [SW-1:0] samp_ls,
  output logic          ack_tgl,
  output logic          new_val
);
  logic req_s;

  sh_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_ls), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  assign new_val = req_s ^ ack_tgl;

  // samp_bus is held steady by the busy gate until this acknowledge returns.
  always_ff @(posedge clk_ls or negedge rst_n) begin
    if (!rst_n) begin
      samp_ls <= '0;
      ack_tgl <= 1'b0;
    end else if (new_val) begin
      samp_ls <= samp_bus;
      ack_tgl <= req_s;
    end
  end
endmodule

// File: rtl/sh_phase_seq.sv
module sh_phase_seq
  import shseq_pkg::*;
#(
  parameter int SW = 10,
  parameter int HW = 10,
  parameter int RW = 8,
  parameter int CW = 10
) (
  input  logic          clk_ls,
  input  logic          rst_n,
  input  logic          en,
  input  logic          conv_req,
  input  logic [SW-1:0] samp_len,
  input  logic [HW-1:0] hold_len,
  input  logic [RW-1:0] ref_len,
  output logic [1:0]    phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          phase_end,
  output logic          core_on,
  output logic          buf_on,
  output logic          out_hiz,
  output logic          cap_conn
);
  phase_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] pre_samp, pre_hold, pre_ref;
  logic [3:0]    ctrl;

  assign pre_samp = CW'(samp_len);
  assign pre_hold = CW'(min1_preload(16'(hold_len)));
  assign pre_ref  = CW'(min1_preload(16'(ref_len)));
  assign phase_end = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = phase_end ? cnt_q : cnt_q - 1'b1;
    if (!en) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        PH_IDLE: begin
          st_d  = PH_SAMPLE;
          cnt_d = pre_samp;
        end
        PH_SAMPLE: if (phase_end) begin
          st_d  = PH_HOLD;
          cnt_d = pre_hold;
        end
        PH_HOLD: begin
          if (conv_req) begin
            st_d  = PH_SAMPLE;
            cnt_d = pre_samp;
          end else if (phase_end) begin
            st_d  = PH_REFRESH;
            cnt_d = pre_ref;
          end
        end
        PH_REFRESH: begin
          if (conv_req) begin
            st_d  = PH_SAMPLE;
            cnt_d = pre_samp;
          end else if (phase_end) begin
            st_d  = PH_HOLD;
            cnt_d = pre_hold;
          end
        end
        default: begin
          st_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_ls or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ctrl     = phase_ctrl(st_q);
  assign core_on  = ctrl[3];
  assign buf_on   = ctrl[2];
  assign out_hiz  = ctrl[1];
  assign cap_conn = ctrl[0];
  assign phase_o  = st_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/sh_dac_seq.sv
module sh_dac_seq #(
  parameter int SAMP_W      = 10,
  parameter int HOLD_W      = 10,
  parameter int REF_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_bus,
  input  logic                 clk_ls,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [SAMP_W-1:0]    wr_data,
  output logic                 busy,
  input  logic                 en,
  input  logic                 conv_req,
  output logic [1:0]           phase,
  output logic                 core_on,
  output logic                 buf_on,
  output logic                 out_hiz,
  output logic                 cap_conn
);
  localparam int CW0 = (SAMP_W > HOLD_W) ? SAMP_W : HOLD_W;
  localparam int CW  = (CW0 > REF_W) ? CW0 : REF_W;

  logic [SAMP_W-1:0] samp_bus, samp_ls;
  logic [HOLD_W-1:0] hold_q;
  logic [REF_W-1:0]  ref_q;
  logic              req_tgl, ack_tgl, new_val;
  logic              samp_take, samp_drop, phase_end;
  logic [CW-1:0]     seq_cnt;

  sh_busregs #(
    .SW(SAMP_W), .HW(HOLD_W), .RW(REF_W), .DW(SAMP_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .clk_bus(clk_bus), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack_tgl(ack_tgl), .samp_q(samp_bus), .hold_q(hold_q),
    .ref_q(ref_q), .req_tgl(req_tgl), .busy(busy), .samp_take(samp_take),
    .samp_drop(samp_drop)
  );

  sh_ls_rx #(.SW(SAMP_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_ls(clk_ls), .rst_n(rst_n), .req_tgl(req_tgl), .samp_bus(samp_bus),
    .samp_ls(samp_ls), .ack_tgl(ack_tgl), .new_val(new_val)
  );

  sh_phase_seq #(.SW(SAMP_W), .HW(HOLD_W), .RW(REF_W), .CW(CW)) u_seq (
    .clk_ls(clk_ls), .rst_n(rst_n), .en(en), .conv_req(conv_req),
    .samp_len(samp_ls), .hold_len(hold_q), .ref_len(ref_q), .phase_o(phase),
    .cnt_o(seq_cnt), .phase_end(phase_end), .core_on(core_on), .buf_on(buf_on),
    .out_hiz(out_hiz), .cap_conn(cap_conn)
  );
endmodule

// File: rtl/sh_dac_seq_chk.sv
module sh_dac_seq_chk #(
  parameter int SW = 10,
  parameter int CW = 10
) (
  input logic          clk_bus,
  input logic          clk_ls,
  input logic          rst_n,
  input logic          en,
  input logic          conv_req,
  input logic [1:0]    phase,
  input logic          core_on,
  input logic          buf_on,
  input logic          out_hiz,
  input logic          cap_conn,
  input logic          busy,
  input logic          samp_take,
  input logic          samp_drop,
  input logic [SW-1:0] samp_bus,
  input logic [CW-1:0] seq_cnt,
  input logic          phase_end
);
  p_hold_gated_r4: assert property (@(posedge clk_ls) disable iff (!rst_n)
    (phase == 2'd2) |-> (!core_on && !buf_on && out_hiz && !cap_conn));

  p_busy_set_r5: assert property (@(posedge clk_bus) disable iff (!rst_n)
    samp_take |=> busy);

  p_drop_write_r6: assert property (@(posedge clk_bus) disable iff (!rst_n)
    samp_drop |=> $stable(samp_bus));

  // R7 and R1: a running sample phase counts down steadily, whatever arrives.
  p_samp_steady_r7: assert property (@(posedge clk_ls) disable iff (!rst_n)
    (phase == 2'd1 && $past(phase) == 2'd1) |-> (seq_cnt == $past(seq_cnt) - 1'b1));

  p_loop_r3: assert property (@(posedge clk_ls) disable iff (!rst_n)
    (phase == 2'd3 && phase_end && en && !conv_req) |=> (phase == 2'd2));

  p_conv_req_r8: assert property (@(posedge clk_ls) disable iff (!rst_n)
    (phase[1] && en && conv_req) |=> (phase == 2'd1));

  p_disable_r9: assert property (@(posedge clk_ls) disable iff (!rst_n)
    !en |=> (phase == 2'd0));
endmodule

bind sh_dac_seq sh_dac_seq_chk #(.SW(SAMP_W), .CW(CW)) u_chk (
  .clk_bus(clk_bus), .clk_ls(clk_ls), .rst_n(rst_n), .en(en), .conv_req(conv_req),
  .phase(phase), .core_on(core_on), .buf_on(buf_on), .out_hiz(out_hiz),
  .cap_conn(cap_conn), .busy(busy), .samp_take(samp_take), .samp_drop(samp_drop),
  .samp_bus(samp_bus), .seq_cnt(seq_cnt), .phase_end(phase_end)
);

// File: tb/tb_sh_dac_seq.sv
module tb_sh_dac_seq;
  logic       clk_bus = 0, clk_ls = 0, rst_n = 0;
  logic       wr_en = 0, en = 0, conv_req = 0;
  logic [1:0] wr_sel = 0;
  logic [9:0] wr_data = 0;
  logic       busy, core_on, buf_on, out_hiz, cap_conn;
  logic [1:0] phase;
  int         checks = 0, failures = 0;

  always #5 clk_bus = ~clk_bus;
  always #37 clk_ls = ~clk_ls;

  sh_dac_seq dut (
    .clk_bus(clk_bus), .clk_ls(clk_ls), .rst_n(rst_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .busy(busy), .en(en), .conv_req(conv_req),
    .phase(phase), .core_on(core_on), .buf_on(buf_on), .out_hiz(out_hiz),
    .cap_conn(cap_conn)
  );

  function automatic int exp_samp(int n); return n + 1; endfunction
  function automatic int exp_min1(int v); return (v == 0) ? 1 : v; endfunction
  function automatic logic [3:0] exp_ctrl(int p);
    return (p == 1 || p == 3) ? 4'b1101 : 4'b0010;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_phase(string req, int p);
    chk(req, int'(phase), p);
    chk("R4", int'({core_on, buf_on, out_hiz, cap_conn}), int'(exp_ctrl(p)));
  endtask

  task automatic bus_write(logic [1:0] sel, int val);
    @(negedge clk_bus);
    wr_en = 1; wr_sel = sel; wr_data = 10'(val);
    @(negedge clk_bus);
    wr_en = 0;
  endtask

  task automatic wait_idle_busy(string req);
    int n = 0;
    while (busy && n < 60) begin @(negedge clk_bus); n++; end
    chk(req, int'(busy), 0);
  endtask

  task automatic write_samp(int val);
    bus_write(2'd0, val);
    chk("R5", int'(busy), 1);
    wait_idle_busy("R5");
  endtask

  // Counts falling low-speed edges that show the same phase code.
  task automatic measure(output int len);
    logic [1:0] p0 = phase;
    len = 0;
    while (phase == p0 && len < 3000) begin len++; @(negedge clk_ls); end
  endtask

  // Enables from idle and checks sample, hold, refresh, hold.
  task automatic run_cycle(int n, int h, int r);
    int len;
    @(negedge clk_ls); en = 1;
    @(negedge clk_ls); chk_phase("R1", 1);
    measure(len); chk("R1", len, exp_samp(n));
    chk_phase("R2", 2);
    measure(len); chk((h == 0) ? "R10" : "R2", len, exp_min1(h));
    chk_phase("R3", 3);
    measure(len); chk((r == 0) ? "R10" : "R3", len, exp_min1(r));
    chk_phase("R3", 2);
    measure(len); chk("R3", len, exp_min1(h));
    en = 0;
    @(negedge clk_ls); chk_phase("R9", 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_bus);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int len, seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk_ls);
    rst_n = 1;
    @(negedge clk_ls);
    chk_phase("R11", 0);
    chk("R11", int'(busy), 0);
    // All registers zero after reset: sample 1, hold 1, refresh 1.
    run_cycle(0, 0, 0);

    // Directed corner: long phases then the small example.
    bus_write(2'd1, 62); bus_write(2'd2, 4); write_samp(11);
    run_cycle(11, 62, 4);
    bus_write(2'd1, 0); bus_write(2'd2, 0); write_samp(3);
    run_cycle(3, 0, 0);

    // Random settings.
    for (int i = 0; i < 6; i++) begin
      int n = int'($urandom_range(0, 15));
      int h = int'($urandom_range(0, 12));
      int r = int'($urandom_range(0, 8));
      bus_write(2'd1, h); bus_write(2'd2, r); write_samp(n);
      run_cycle(n, h, r);
    end

    // R6: a second write while busy is dropped.
    bus_write(2'd1, 5); bus_write(2'd2, 3);
    bus_write(2'd0, 6);
    bus_write(2'd0, 20);
    wait_idle_busy("R6");
    @(negedge clk_ls); en = 1;
    @(negedge clk_ls); measure(len); chk("R6", len, exp_samp(6));
    en = 0; @(negedge clk_ls);

    // R7: change on the fly during a long sample phase.
    write_samp(30);
    @(negedge clk_ls); en = 1;
    @(negedge clk_ls);
    fork
      measure(len);
      begin bus_write(2'd0, 2); wait_idle_busy("R7"); end
    join
    chk("R7", len, exp_samp(30));
    chk_phase("R7", 2);
    // R8: request in hold starts the new sample length.
    conv_req = 1;
    @(negedge clk_ls); conv_req = 0;
    chk_phase("R8", 1);
    measure(len); chk("R7", len, exp_samp(2));
    measure(len); chk("R2", len, 5);
    chk_phase("R8", 3);
    conv_req = 1;
    @(negedge clk_ls); conv_req = 0;
    chk_phase("R8", 1);
    // R8: request during sample is ignored.
    conv_req = 1;
    @(negedge clk_ls); conv_req = 0;
    measure(len); chk("R8", len + 1, exp_samp(2) - 1 + 1);
    chk_phase("R8", 2);

    // R9: disable mid-hold, then request while idle is ignored.
    en = 0;
    @(negedge clk_ls); chk_phase("R9", 0);
    conv_req = 1;
    @(negedge clk_ls); conv_req = 0;
    @(negedge clk_ls); chk_phase("R8", 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule